// File: doc/BRIEF.md
# Aperture address remapping table

This block remaps device addresses that fall inside a fixed window of address space. The window is cut into 4 KB pages, and each page has its own table entry that names a physical page. A lookup port takes a device address and, one clock later, returns the physical address or a fault. The page offset, bits [11:0], passes through unchanged.

Software never addresses the table directly. It writes a device address into a selector word, and a data word then reads or writes the entry of the page that holds that address. A third word holds a single enable bit. While this bit is clear, every lookup faults.

The window base and the number of pages are parameters. The base must be 4 KB aligned. The page index is (address - base) >> 12.

Top module: `aperture_remap`

## Requirements
- R1: After reset, the enable bit reads 0, the selector reads 0, every entry is invalid, and a lookup faults.
- R2: Register offset 0x0 holds the enable bit in bit 0, and the other bits of that word read 0. Offset 0x4 holds the selector, and all 32 bits read back as written.
- R3: A write to offset 0x8 stores bit 31 (valid) and bits [30:12] (physical page number) into the entry of the page the selector points at. A read of offset 0x8 returns that entry with every other bit 0.
- R4: While the enable bit is 0, every lookup returns fault=1 and address 0. Writing 1 to offset 0x0 turns translation back on.
- R5: A lookup of an in-window address whose entry is valid, with translation on, returns fault=0 and address {1'b0, page number, lookup address[11:0]}.
- R6: A lookup below the base, or at or above base + pages*4096, returns fault=1 and address 0. The last page of the window translates normally.
- R7: A lookup of a page whose entry is invalid returns fault=1 and address 0. Writing the value 0 to an entry unmaps that page.
- R8: rsp_valid is high exactly one cycle after lk_valid is high. While rsp_valid is low, rsp_fault and rsp_paddr are 0.
- R9: A lookup issued in the same cycle as an entry write sees the old entry. A lookup issued in the next cycle sees the new entry.
- R10: An entry write while the selector lies outside the window changes no entry. An entry read in that state returns 0.
- R11: Writes to any offset other than 0x0, 0x4 and 0x8 change nothing, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational, from reg_addr) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Device address to translate |
| rsp_valid | output | 1 | Lookup result valid, one cycle after the request |
| rsp_fault | output | 1 | Lookup faulted |
| rsp_paddr | output | 32 | Translated physical address, 0 on a fault |

## Verification
The assertions assume that reset is held for at least one clock edge, that lk_valid and the register strobe are driven to known values on every edge, and that the base parameter is 4 KB aligned. The stimulus changes every input half a period away from the rising edge and holds the register strobe for exactly one edge per write. The bench runs the one parameter set whose window does not wrap the 32-bit address space. Lookups that probe the bounds are placed one byte below the base, on the first byte past the window, and on the last byte of the final page.

// File: rtl/aperture_remap_pkg.sv
package aperture_remap_pkg;

    localparam int PAGE_SHIFT = 12;
    localparam int PPN_W      = 31 - PAGE_SHIFT;

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_SEL  = 4'h4;
    localparam logic [3:0] OFS_ENT  = 4'h8;

    typedef struct packed {
        logic             valid;
        logic [PPN_W-1:0] ppn;
    } map_entry_t;

    typedef struct packed {
        logic        fault;
        logic [31:0] paddr;
    } xlate_rsp_t;

    function automatic map_entry_t entry_from_word(input logic [31:PAGE_SHIFT] w);
        map_entry_t e;
        e.valid = w[31];
        e.ppn   = w[30:PAGE_SHIFT];
        return e;
    endfunction

    function automatic logic [31:0] entry_to_word(input map_entry_t e);
        return {e.valid, e.ppn, {PAGE_SHIFT{1'b0}}};
    endfunction

    function automatic logic in_window(input logic [31:0] a,
                                       input logic [31:0] base,
                                       input int unsigned npages);
        logic [32:0] lim;
        lim = {1'b0, base} + (33'(npages) << PAGE_SHIFT);
        return (a >= base) && ({1'b0, a} < lim);
    endfunction

    function automatic logic [31:0] page_offset(input logic [31:0] a,
                                                input logic [31:0] base);
        return (a - base) >> PAGE_SHIFT;
    endfunction

endpackage

// File: rtl/apr_regbank.sv
module apr_regbank
    import aperture_remap_pkg::*;
#(
    parameter logic [31:0] BASE      = 32'h0100_0000,
    parameter int unsigned NUM_PAGES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wen,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  map_entry_t  sel_entry,
    output logic        xlate_en,
    output logic [31:0] sel_addr,
    output logic        ent_wen,
    output map_entry_t  ent_wval
);
    logic sel_hit;

    assign sel_hit  = in_window(sel_addr, BASE, NUM_PAGES);
    assign ent_wen  = reg_wen && (reg_addr == OFS_ENT) && sel_hit;
    assign ent_wval = entry_from_word(reg_wdata[31:PAGE_SHIFT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            xlate_en <= 1'b0;
            sel_addr <= '0;
        end else if (reg_wen) begin
            if (reg_addr == OFS_CTRL) xlate_en <= reg_wdata[0];
            if (reg_addr == OFS_SEL)  sel_addr <= reg_wdata;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_CTRL: reg_rdata = {31'b0, xlate_en};
            OFS_SEL:  reg_rdata = sel_addr;
            OFS_ENT:  reg_rdata = sel_hit ? entry_to_word(sel_entry) : '0;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/apr_table.sv
module apr_table
    import aperture_remap_pkg::*;
#(
    parameter int unsigned NUM_PAGES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_off,
    input  map_entry_t  wr_val,
    input  logic [31:0] sel_off,
    output map_entry_t  sel_val,
    input  logic [31:0] lk_off,
    output map_entry_t  lk_val
);
    map_entry_t mem [NUM_PAGES];

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (wr_en && (wr_off == 32'(g)))
                mem[g] <= wr_val;
        end
    end

    always_comb begin
        sel_val = '0;
        lk_val  = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            if (sel_off == 32'(i)) sel_val = mem[i];
            if (lk_off  == 32'(i)) lk_val  = mem[i];
        end
    end
endmodule

// File: rtl/apr_xlate.sv
module apr_xlate
    import aperture_remap_pkg::*;
#(
    parameter logic [31:0] BASE      = 32'h0100_0000,
    parameter int unsigned NUM_PAGES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        xlate_en,
    input  logic        lk_valid,
    input  logic [31:0] lk_addr,
    input  map_entry_t  lk_entry,
    output logic        rsp_valid,
    output xlate_rsp_t  rsp
);
    xlate_rsp_t nxt;

    always_comb begin
        nxt = '0;
        if (lk_valid) begin
            if (!xlate_en || !in_window(lk_addr, BASE, NUM_PAGES) || !lk_entry.valid)
                nxt.fault = 1'b1;
            else
                nxt.paddr = {1'b0, lk_entry.ppn, lk_addr[PAGE_SHIFT-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp       <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp       <= nxt;
        end
    end
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
    import aperture_remap_pkg::*;
#(
    parameter logic [31:0] APT_BASE  = 32'h0100_0000,
    parameter int unsigned NUM_PAGES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wen,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        lk_valid,
    input  logic [31:0] lk_addr,
    output logic        rsp_valid,
    output logic        rsp_fault,
    output logic [31:0] rsp_paddr
);
    logic        xlate_en;
    logic [31:0] sel_addr;
    logic [31:0] sel_off;
    logic [31:0] lk_off;
    logic        ent_wen;
    map_entry_t  ent_wval;
    map_entry_t  sel_entry;
    map_entry_t  lk_entry;
    xlate_rsp_t  rsp;

    assign sel_off = page_offset(sel_addr, APT_BASE);
    assign lk_off  = page_offset(lk_addr, APT_BASE);

    apr_regbank #(.BASE(APT_BASE), .NUM_PAGES(NUM_PAGES)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sel_entry(sel_entry),
        .xlate_en(xlate_en), .sel_addr(sel_addr),
        .ent_wen(ent_wen), .ent_wval(ent_wval)
    );

    apr_table #(.NUM_PAGES(NUM_PAGES)) u_table (
        .clk(clk), .rst(rst),
        .wr_en(ent_wen), .wr_off(sel_off), .wr_val(ent_wval),
        .sel_off(sel_off), .sel_val(sel_entry),
        .lk_off(lk_off), .lk_val(lk_entry)
    );

    apr_xlate #(.BASE(APT_BASE), .NUM_PAGES(NUM_PAGES)) u_xlate (
        .clk(clk), .rst(rst),
        .xlate_en(xlate_en), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_entry(lk_entry), .rsp_valid(rsp_valid), .rsp(rsp)
    );

    assign rsp_fault = rsp.fault;
    assign rsp_paddr = rsp.paddr;
endmodule

// File: rtl/aperture_remap_chk.sv
module aperture_remap_chk #(
    parameter logic [31:0] BASE = 32'h0100_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        lk_valid,
    input logic [31:0] lk_addr,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [31:0] rsp_paddr,
    input logic        xlate_en,
    input logic [3:0]  reg_addr,
    input logic [31:0] reg_rdata
);
    // R1
    reset_off_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !xlate_en);

    // R4
    disabled_faults_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !xlate_en) |=> (rsp_fault && rsp_paddr == 32'h0));

    // R5
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (rsp_fault || (rsp_paddr[11:0] == $past(lk_addr[11:0]) && !rsp_paddr[31])));

    // R6
    below_base_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_addr < BASE) |=> rsp_fault);

    // R7
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_valid && rsp_paddr == 32'h0));

    // R8
    rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    // R8
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!rsp_valid && !rsp_fault && rsp_paddr == 32'h0));

    // R11
    hole_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr != 4'h0 && reg_addr != 4'h4 && reg_addr != 4'h8) |-> reg_rdata == 32'h0);
endmodule

bind aperture_remap aperture_remap_chk #(.BASE(APT_BASE)) u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .xlate_en(xlate_en), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/aperture_remap_tb.sv
module aperture_remap_tb;
    localparam logic [31:0] BASE = 32'h0100_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wen = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_paddr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    aperture_remap #(.APT_BASE(BASE), .NUM_PAGES(16)) u_dut (
        .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr)
    );

    task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_read(input string req, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, {1'b0, reg_rdata}, {1'b0, exp});
    endtask

    task automatic lookup(input string req, input logic [31:0] a,
                          input logic efault, input logic [31:0] epa);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        check({req, " valid"}, {32'h0, rsp_valid}, 33'h1);
        check(req, {rsp_fault, rsp_paddr}, {efault, epa});
    endtask

    task automatic map_page(input logic [31:0] va, input logic [31:0] w);
        reg_write(4'h4, va);
        reg_write(4'h8, w);
    endtask

    task automatic t_reset();
        reg_read("R1 ctrl", 4'h0, 32'h0);
        reg_read("R1 sel", 4'h4, 32'h0);
        reg_write(4'h4, BASE + 32'h2000);
        reg_read("R1 entry", 4'h8, 32'h0);
        reg_write(4'h0, 32'h1);
        lookup("R1 lookup", BASE + 32'h2010, 1'b1, 32'h0);
        reg_write(4'h0, 32'h0);
    endtask

    task automatic t_regs();
        reg_write(4'h0, 32'hFFFF_FFFF);
        reg_read("R2 ctrl", 4'h0, 32'h1);
        reg_write(4'h4, 32'h0100_3ABC);
        reg_read("R2 sel", 4'h4, 32'h0100_3ABC);
    endtask

    task automatic t_program();
        map_page(BASE + 32'h3000, 32'hFFFF_FFFF);
        reg_read("R3 masked", 4'h8, 32'hFFFF_F000);
        map_page(BASE + 32'h3000, 32'h8001_2345);
        reg_read("R3 entry", 4'h8, 32'h8001_2000);
    endtask

    task automatic t_translate();
        lookup("R5 page3", BASE + 32'h3ABC, 1'b0, 32'h0001_2ABC);
        map_page(BASE + 32'h0000, 32'h8765_4000);
        lookup("R5 page0", BASE + 32'h0004, 1'b0, 32'h0765_4004);
        map_page(BASE + 32'hF000, 32'hC000_0000);
        lookup("R6 last page", BASE + 32'hFFFF, 1'b0, 32'h4000_0FFF);
    endtask

    task automatic t_bounds();
        lookup("R6 below", BASE - 32'h1, 1'b1, 32'h0);
        lookup("R6 end", BASE + 32'h1_0000, 1'b1, 32'h0);
    endtask

    task automatic t_invalid();
        lookup("R7 never mapped", BASE + 32'h5000, 1'b1, 32'h0);
        map_page(BASE + 32'h3000, 32'h0);
        reg_read("R7 unmapped read", 4'h8, 32'h0);
        lookup("R7 unmapped", BASE + 32'h3ABC, 1'b1, 32'h0);
    endtask

    task automatic t_disable();
        reg_write(4'h0, 32'h0);
        lookup("R4 off", BASE + 32'h0004, 1'b1, 32'h0);
        reg_write(4'h0, 32'h1);
        lookup("R4 back on", BASE + 32'h0004, 1'b0, 32'h0765_4004);
    endtask

    task automatic t_latency();
        @(negedge clk);
        check("R8 idle valid", {32'h0, rsp_valid}, 33'h0);
        check("R8 idle data", {rsp_fault, rsp_paddr}, 33'h0);
    endtask

    task automatic t_order();
        reg_write(4'h4, BASE + 32'h6000);
        reg_wen = 1'b1; reg_addr = 4'h8; reg_wdata = 32'h8000_A000;
        lk_valid = 1'b1; lk_addr = BASE + 32'h6123;
        @(negedge clk);
        reg_wen = 1'b0; lk_valid = 1'b0;
        check("R9 same cycle", {rsp_fault, rsp_paddr}, {1'b1, 32'h0});
        lookup("R9 next cycle", BASE + 32'h6123, 1'b0, 32'h0000_A123);
    endtask

    task automatic t_ignored();
        reg_write(4'h4, 32'h0200_0000);
        reg_write(4'h8, 32'h8000_1000);
        reg_read("R10 outside read", 4'h8, 32'h0);
        lookup("R10 page0 intact", BASE + 32'h0008, 1'b0, 32'h0765_4008);
        reg_write(4'hC, 32'hFFFF_FFFF);
        reg_read("R11 hole read", 4'hC, 32'h0);
        reg_read("R11 ctrl kept", 4'h0, 32'h1);
        reg_read("R11 sel kept", 4'h4, 32'h0200_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 rsp idle", {rsp_fault, rsp_paddr}, 33'h0);
        t_reset();
        t_regs();
        t_program();
        t_translate();
        t_bounds();
        t_invalid();
        t_disable();
        t_latency();
        t_order();
        t_ignored();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule